// File: doc/BRIEF.md
# Staged Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream through two register stages. A storage stage captures the parallel input word whenever its strobe is high. A shift stage of the same width is filled from the storage stage by an active-low load level. It is emptied by an active-low clear level, and it advances one place per shift strobe, taking a new bit from a serial input at its low end. The serial output is the most significant bit of the shift stage. Because the two stages are separate, the next word can be staged while the current word is still being shifted out.

Every state change happens on the rising edge of one system clock. The two strobes act as single-cycle clock enables. The load and clear levels are sampled on every edge, and the shift stage applies them in this order: clear first, then load, then shift, then hold. If a load and a storage strobe arrive in the same cycle, the new input word goes straight into the shift stage. Driving load and clear low together is an illegal request. The block handles it in one fixed way: it empties the shift stage and latches an error flag. The flag stays set until the acknowledge input is pulsed.

A per-cycle decoder names the shift-stage operation: OP_HOLD, OP_SHIFT, OP_LOAD, OP_CLEAR or OP_CONFLICT. The error flag is a two-state machine. It moves from ERR_CLEAN to ERR_FLAGGED on any OP_CONFLICT cycle. It returns from ERR_FLAGGED to ERR_CLEAN on an acknowledge cycle with no conflict. In every other case it stays where it is.

Top module: `staged_piso`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the storage stage, the shift stage and the error flag to zero.
- R2: With stage_en high at an edge, the storage stage takes par_in, whatever the levels of shift_en, load_n and clear_n.
- R3: With load_n low, clear_n high and stage_en low, the shift stage takes the storage-stage word at the edge, and shift_en is not needed.
- R4: With load_n low, clear_n high and stage_en high, the shift stage takes par_in directly at that same edge.
- R5: With clear_n low and load_n high, the shift stage becomes all zeros, even when shift_en is high.
- R6: With load_n and clear_n both high and shift_en high, bit n of the shift stage takes bit n-1 and bit 0 takes ser_in. With shift_en low, the shift stage holds its value.
- R7: ser_out always shows bit WIDTH-1 of the shift stage, so the first bit out after a load is the most significant bit of the loaded word.
- R8: A clear leaves the storage stage unchanged, so a later load without a strobe returns the word staged before the clear.
- R9: load_n and clear_n both low is a conflict. The shift stage becomes all zeros and conflict_err is set at that edge.
- R10: conflict_err stays set until an edge where err_ack is high and no conflict is present. A conflict at the same edge as err_ack keeps the flag set.
- R11: A storage strobe during a shift sequence without load has no effect on the bits being shifted out. The new word appears only after the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel data word |
| stage_en | input | 1 | Storage-stage capture strobe |
| shift_en | input | 1 | Shift-stage advance strobe |
| ser_in | input | 1 | Bit entering shift-stage bit 0 |
| load_n | input | 1 | Load level from storage stage, active low |
| clear_n | input | 1 | Clear level for shift stage, active low |
| err_ack | input | 1 | Clears the sticky conflict flag |
| ser_out | output | 1 | Serial output, shift-stage MSB |
| conflict_err | output | 1 | Sticky flag for a load-plus-clear conflict |

## Verification
The bench stages every 8-bit word, loads it, and shifts it out while feeding a known pattern into ser_in. A design with the wrong shift direction, wrong output bit or wrong fill bit would show a mismatch on the first or last bits of each word. A separate test strobes a load in the same cycle as a new word. A design that routes the load through the old storage value would emit the stale word there. Other tests stage a word in the middle of a shift run and clear the shift stage while a shift is requested. A design that lets the storage stage leak into the shifter, or that lets the shift win over the clear, would show the wrong bits. Conflict cycles are reported as illegal and their data is not checked. The bench does check the sticky flag, including an acknowledge in the same cycle as a conflict: a flag that clears too early, or never sets, fails there.

// File: rtl/staged_piso_pkg.sv
package staged_piso_pkg;

    // Operation applied to the shift stage in the current cycle
    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_SHIFT    = 3'd1,
        OP_LOAD     = 3'd2,
        OP_CLEAR    = 3'd3,
        OP_CONFLICT = 3'd4
    } shift_op_e;

    // Sticky error flag machine
    typedef enum logic {
        ERR_CLEAN   = 1'b0,
        ERR_FLAGGED = 1'b1
    } err_state_e;

endpackage

// File: rtl/staged_piso_op_decode.sv
module staged_piso_op_decode
    import staged_piso_pkg::*;
(
    input  logic      load_n,
    input  logic      clear_n,
    input  logic      shift_en,
    output shift_op_e op
);

    // Priority: conflict, clear, load, shift, hold
    always_comb begin
        op = OP_HOLD;
        unique case ({load_n, clear_n})
            2'b00: op = OP_CONFLICT;
            2'b10: op = OP_CLEAR;
            2'b01: op = OP_LOAD;
            2'b11: op = shift_en ? OP_SHIFT : OP_HOLD;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/staged_piso_stage_reg.sv
module staged_piso_stage_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stage_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else if (stage_en)
            stage_q <= par_in;
    end

endmodule

// File: rtl/staged_piso_shift_chain.sv
module staged_piso_shift_chain
    import staged_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  shift_op_e        op,
    input  logic [WIDTH-1:0] load_word,
    input  logic             ser_in,
    output logic [WIDTH-1:0] shift_q
);

    logic [WIDTH-1:0] shift_d;

    // One next-value selector per bit; bit 0 takes the serial input
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_bit;
        if (i == 0) begin : g_low
            assign up_bit = ser_in;
        end else begin : g_up
            assign up_bit = shift_q[i-1];
        end

        always_comb begin
            shift_d[i] = shift_q[i];
            unique case (op)
                OP_HOLD:     shift_d[i] = shift_q[i];
                OP_SHIFT:    shift_d[i] = up_bit;
                OP_LOAD:     shift_d[i] = load_word[i];
                OP_CLEAR:    shift_d[i] = 1'b0;
                OP_CONFLICT: shift_d[i] = 1'b0;
                default:     shift_d[i] = shift_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else
            shift_q <= shift_d;
    end

endmodule

// File: rtl/staged_piso_err_fsm.sv
module staged_piso_err_fsm
    import staged_piso_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  shift_op_e op,
    input  logic      err_ack,
    output logic      err_flag
);

    err_state_e state_q;
    err_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAN: begin
                if (op == OP_CONFLICT)
                    state_d = ERR_FLAGGED;
            end
            ERR_FLAGGED: begin
                if (op != OP_CONFLICT && err_ack)
                    state_d = ERR_CLEAN;
            end
            default: state_d = ERR_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ERR_CLEAN;
        else
            state_q <= state_d;
    end

    always_comb begin
        err_flag = (state_q == ERR_FLAGGED);
    end

endmodule

// File: rtl/staged_piso.sv
module staged_piso
    import staged_piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             stage_en,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic             load_n,
    input  logic             clear_n,
    input  logic             err_ack,
    output logic             ser_out,
    output logic             conflict_err
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] load_word;
    shift_op_e        op;

    staged_piso_op_decode u_dec (
        .load_n   (load_n),
        .clear_n  (clear_n),
        .shift_en (shift_en),
        .op       (op)
    );

    staged_piso_stage_reg #(.WIDTH(WIDTH)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .stage_en (stage_en),
        .par_in   (par_in),
        .stage_q  (stage_q)
    );

    // A word staged in the same cycle as a load passes straight through
    assign load_word = stage_en ? par_in : stage_q;

    staged_piso_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_word (load_word),
        .ser_in    (ser_in),
        .shift_q   (shift_q)
    );

    staged_piso_err_fsm u_err (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .err_ack  (err_ack),
        .err_flag (conflict_err)
    );

    assign ser_out = shift_q[MSB];

endmodule

// File: rtl/staged_piso_chk.sv
module staged_piso_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] par_in,
    input logic             stage_en,
    input logic             shift_en,
    input logic             ser_in,
    input logic             load_n,
    input logic             clear_n,
    input logic             err_ack,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] shift_q,
    input logic             conflict_err
);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (stage_q == '0 && shift_q == '0 && !conflict_err));

    // R2
    stage_capture_chk: assert property (@(posedge clk) disable iff (rst)
        stage_en |=> stage_q == $past(par_in));

    // R3
    load_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n && clear_n && !stage_en) |=> shift_q == $past(stage_q));

    // R4
    load_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n && clear_n && stage_en) |=> shift_q == $past(par_in));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !clear_n) |=> shift_q == '0);

    // R6
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && clear_n && shift_en) |=>
            shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)});

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && clear_n && !shift_en) |=> $stable(shift_q));

    // R8
    clear_keeps_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear_n && !stage_en) |=> $stable(stage_q));

    // R9
    conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !clear_n) |=> (conflict_err && shift_q == '0));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (conflict_err && !err_ack) |=> conflict_err);

    // R10
    flag_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (err_ack && !(!load_n && !clear_n)) |=> !conflict_err);

endmodule

bind staged_piso staged_piso_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .par_in       (par_in),
    .stage_en     (stage_en),
    .shift_en     (shift_en),
    .ser_in       (ser_in),
    .load_n       (load_n),
    .clear_n      (clear_n),
    .err_ack      (err_ack),
    .stage_q      (stage_q),
    .shift_q      (shift_q),
    .conflict_err (conflict_err)
);

// File: tb/staged_piso_test.sv
module staged_piso_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] par_in;
    logic       stage_en, shift_en, ser_in, load_n, clear_n, err_ack;
    logic       ser_out, conflict_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model
    logic [7:0] m_stage, m_shift;
    logic       m_err;
    bit         m_valid;

    always #5 clk = ~clk;

    staged_piso #(.WIDTH(8)) uut (
        .clk(clk), .rst(rst), .par_in(par_in), .stage_en(stage_en),
        .shift_en(shift_en), .ser_in(ser_in), .load_n(load_n),
        .clear_n(clear_n), .err_ack(err_ack), .ser_out(ser_out),
        .conflict_err(conflict_err)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock with the given inputs; model updated; outputs checked at the falling edge
    task automatic cyc(input logic r, input logic se, input logic [7:0] pi,
                       input logic sh, input logic si, input logic ln,
                       input logic cn, input logic ea, input string tag);
        logic [7:0] src;
        rst = r; stage_en = se; par_in = pi; shift_en = sh; ser_in = si;
        load_n = ln; clear_n = cn; err_ack = ea;
        @(posedge clk);
        src = se ? pi : m_stage;
        if (r) begin
            m_stage = 8'h00; m_shift = 8'h00; m_err = 1'b0; m_valid = 1'b1;
        end else begin
            if (!ln && !cn) begin
                $display("NOTE illegal load+clear request flagged at %0t", $time);
                m_valid = 1'b0; m_shift = 8'h00;
            end else if (!cn) begin
                m_shift = 8'h00; m_valid = 1'b1;
            end else if (!ln) begin
                m_shift = src; m_valid = 1'b1;
            end else if (sh) begin
                m_shift = {m_shift[6:0], si};
            end
            if (se) m_stage = pi;
            if (!ln && !cn) m_err = 1'b1;
            else if (ea)    m_err = 1'b0;
        end
        @(negedge clk);
        if (m_valid) check(ser_out, m_shift[7], tag);
        check(conflict_err, m_err, (tag == "R9" || tag == "R10") ? tag : "R10 flag");
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 8'h00, 0, 0, 1, 1, 0, tag);
    endtask

    task automatic shift_out(input logic [7:0] fill, input string tag);
        for (int k = 7; k >= 0; k--) cyc(0, 0, 8'h00, 1, fill[k], 1, 1, 0, tag);
    endtask

    initial begin
        m_stage = 8'h00; m_shift = 8'h00; m_err = 1'b0; m_valid = 1'b0;
        rst = 1; stage_en = 0; par_in = 0; shift_en = 0; ser_in = 0;
        load_n = 1; clear_n = 1; err_ack = 0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) cyc(1, 0, 8'hFF, 1, 1, 1, 1, 0, "R1");
        check(ser_out, 1'b0, "R1");
        check(conflict_err, 1'b0, "R1");
        // R1: storage stage is zero after reset
        cyc(0, 0, 8'hA5, 0, 0, 0, 1, 0, "R1");
        shift_out(8'h00, "R1");

        // R2 R3 R6 R7: sweep of all words, shifted out with ~word as fill
        for (int v = 0; v < 256; v++) begin
            cyc(0, 1, v[7:0], 1, 1, 1, 1, 0, "R2");
            cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, "R3");
            shift_out(~v[7:0], "R7");
            shift_out(8'h00, "R6");
        end

        // R6: hold when no strobe
        cyc(0, 1, 8'hC3, 0, 0, 1, 1, 0, "R2");
        cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, "R3");
        for (int k = 0; k < 4; k++) idle("R6");
        shift_out(8'h5A, "R6");

        // R4: load with a strobe in the same cycle passes the new word
        for (int v = 0; v < 256; v += 17) begin
            cyc(0, 1, 8'h3C, 0, 0, 1, 1, 0, "R2");
            cyc(0, 1, v[7:0], 0, 0, 0, 1, 0, "R4");
            shift_out(8'h00, "R4");
        end

        // R11: staging during a shift run does not disturb the output
        cyc(0, 1, 8'hE1, 0, 0, 1, 1, 0, "R2");
        cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, "R3");
        cyc(0, 0, 8'h00, 1, 0, 1, 1, 0, "R11");
        cyc(0, 0, 8'h00, 1, 1, 1, 1, 0, "R11");
        cyc(0, 1, 8'h1E, 1, 0, 1, 1, 0, "R11");
        shift_out(8'h96, "R11");
        cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, "R11");
        shift_out(8'h00, "R11");

        // R5 R8: clear beats shift and keeps the staged word
        cyc(0, 1, 8'hB7, 0, 0, 0, 1, 0, "R4");
        cyc(0, 0, 8'h00, 1, 1, 1, 0, 0, "R5");
        check(ser_out, 1'b0, "R5");
        cyc(0, 0, 8'h00, 1, 1, 1, 0, 0, "R5");
        shift_out(8'h00, "R5");
        cyc(0, 0, 8'h00, 0, 0, 0, 1, 0, "R8");
        shift_out(8'h00, "R8");

        // R9 R10: conflict flagged, sticky, ack loses to a conflict
        cyc(0, 0, 8'h00, 1, 1, 0, 0, 0, "R9");
        check(conflict_err, 1'b1, "R9");
        idle("R10");
        idle("R10");
        cyc(0, 0, 8'h00, 0, 0, 0, 0, 1, "R10");
        check(conflict_err, 1'b1, "R10");
        cyc(0, 0, 8'h00, 0, 0, 1, 1, 1, "R10");
        check(conflict_err, 1'b0, "R10");
        cyc(0, 1, 8'h81, 0, 0, 0, 1, 0, "R4");
        shift_out(8'h00, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule